// File: doc/BRIEF.md
# Dual Lookup Table with Memory and Shift Modes

This block holds two 16-entry single-bit storage cells that together form one slice-level lookup resource. A mode register chooses how the cells are used. Each cell can be a fixed 4-input logic function read by its address. The pair can also act as two independent 16x1 memories, one 16x2 memory, one 32x1 memory, or a 16x1 memory with one write/read port and a second read-only port. In the last mode the pair is a cascaded serial shift chain whose taps can be selected by address.

Both storage images and the mode are written together through a configuration load port. Reads are combinational in every mode. A write or a shift step takes effect on a rising clock edge while `wr_en` is high.

The mode register is the block's state machine. Its states are LOGIC, RAM_SPLIT, RAM_WIDE, RAM_DEEP, RAM_DUAL and SHIFT. Reset enters LOGIC. The only transition is "reconfigure": when `cfg_load` is high, any state moves to the state encoded on `cfg_mode`. Without `cfg_load`, every state holds.

Top module: `lut_pair_slice`

## Requirements
- R1: After reset both tables hold all zeros, the mode is LOGIC (code 0), and `lut_out_a`, `lut_out_b` and `shift_out` read 0 for every address.
- R2: On a clock edge with `cfg_load` high, table A takes `cfg_init_a`, table B takes `cfg_init_b` (bit i is entry i), and the mode takes `cfg_mode`. This overrides any write or shift in that cycle.
- R3: Reads are combinational. Outside RAM_DEEP, `lut_out_a` equals table A entry `addr_a`. Outside RAM_WIDE, RAM_DEEP and RAM_DUAL, `lut_out_b` equals table B entry `addr_b`.
- R4: In LOGIC (code 0) the contents never change, whatever `wr_en`, `wr_data` or `shift_in` do.
- R5: In RAM_SPLIT (code 1) with `wr_en` high, table A entry `addr_a` takes `wr_data[0]` and table B entry `addr_b` takes `wr_data[1]`.
- R6: In RAM_WIDE (code 2) both tables use `addr_a`. A write stores `wr_data[0]` in A and `wr_data[1]` in B. `lut_out_b` reads B entry `addr_a`.
- R7: In RAM_DEEP (code 3) the address is {`addr_b[0]`, `addr_a`}, where `addr_b[0]`=1 selects table B. A write stores `wr_data[0]` only in the selected table. `lut_out_a` reads the selected entry and `lut_out_b` is 0.
- R8: In RAM_DUAL (code 4) a write stores `wr_data[0]` at `addr_a` in both tables. `lut_out_a` reads entry `addr_a` and `lut_out_b` reads entry `addr_b`.
- R9: In SHIFT (code 5) each edge with `wr_en` high moves every entry up by one. `shift_in` enters A entry 0, A entry 15 enters B entry 0, and `addr_a`/`addr_b` select the taps read on `lut_out_a`/`lut_out_b`.
- R10: `shift_out` always equals table B entry 15, so in SHIFT it is the end of the 32-bit chain.
- R11: Mode codes 6 and 7 are loaded as LOGIC, so writes then have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load both images and the mode |
| cfg_mode | input | 3 | Mode code to load |
| cfg_init_a | input | 16 | Contents image for table A |
| cfg_init_b | input | 16 | Contents image for table B |
| addr_a | input | 4 | Address / tap select, port A |
| addr_b | input | 4 | Address / tap select, port B; bit 0 is the table select in RAM_DEEP |
| wr_en | input | 1 | Write or shift enable |
| wr_data | input | 2 | Write data bits |
| shift_in | input | 1 | Serial input of the shift chain |
| lut_out_a | output | 1 | Read result, port A |
| lut_out_b | output | 1 | Read result, port B |
| shift_out | output | 1 | Table B entry 15 |

## Verification
Some relations can be checked on every cycle, and the assertions do so. In LOGIC an unchanged address gives an unchanged output. A write in RAM_WIDE or RAM_DUAL reads back at once on the affected port. A shift puts `shift_in` on tap 0. RAM_DEEP holds `lut_out_b` low. A load in LOGIC shows the image at once. Other behaviours depend on the full contents, and only the bench's sweeps can show them. These are the separation of the two tables in RAM_SPLIT and RAM_DEEP, the handling of the unused mode codes, the cascade across 32 shift steps, and the priority of a load over a simultaneous write. The bench checks these against a bit-level model of both tables, at every address.

// File: rtl/lutp_pkg.sv
package lutp_pkg;

    typedef enum logic [2:0] {
        MODE_LOGIC     = 3'd0,
        MODE_RAM_SPLIT = 3'd1,
        MODE_RAM_WIDE  = 3'd2,
        MODE_RAM_DEEP  = 3'd3,
        MODE_RAM_DUAL  = 3'd4,
        MODE_SHIFT     = 3'd5
    } lutp_mode_e;

    // Unused codes fall back to the read-only logic mode.
    function automatic lutp_mode_e decode_mode(input logic [2:0] code);
        lutp_mode_e m;
        unique case (code)
            3'd1:    m = MODE_RAM_SPLIT;
            3'd2:    m = MODE_RAM_WIDE;
            3'd3:    m = MODE_RAM_DEEP;
            3'd4:    m = MODE_RAM_DUAL;
            3'd5:    m = MODE_SHIFT;
            default: m = MODE_LOGIC;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/lutp_table.sv
module lutp_table #(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DEPTH-1:0]  init,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic              wbit,
    input  logic              sh_en,
    input  logic              sh_in,
    input  logic [ADDR_W-1:0] raddr,
    output logic              rdata,
    output logic              tap_last
);

    logic [DEPTH-1:0] cells;

    // Load outranks shift, and shift outranks a single-entry write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cells <= '0;
        end else if (load) begin
            cells <= init;
        end else if (sh_en) begin
            cells <= {cells[DEPTH-2:0], sh_in};
        end else if (we) begin
            cells[waddr] <= wbit;
        end
    end

    assign rdata    = cells[raddr];
    assign tap_last = cells[DEPTH-1];

endmodule

// File: rtl/lutp_ctrl.sv
module lutp_ctrl
    import lutp_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [2:0]        cfg_mode,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic              wr_en,
    input  logic [1:0]        wr_data,
    output lutp_mode_e        mode,
    output logic [1:0]        we_t,
    output logic [ADDR_W-1:0] waddr_a,
    output logic [ADDR_W-1:0] waddr_b,
    output logic [1:0]        wbit_t,
    output logic              sh_en,
    output logic [ADDR_W-1:0] raddr_a,
    output logic [ADDR_W-1:0] raddr_b,
    output logic              out_a_from_b,
    output logic              out_b_zero
);

    lutp_mode_e state_q;
    lutp_mode_e state_d;

    // Only one transition exists: reconfiguration by a load.
    always_comb begin
        state_d = state_q;
        if (cfg_load) begin
            state_d = decode_mode(cfg_mode);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MODE_LOGIC;
        end else begin
            state_q <= state_d;
        end
    end

    assign mode = state_q;

    // Steering of write, shift and read paths for each state.
    always_comb begin
        we_t         = 2'b00;
        waddr_a      = addr_a;
        waddr_b      = addr_b;
        wbit_t       = wr_data;
        sh_en        = 1'b0;
        raddr_a      = addr_a;
        raddr_b      = addr_b;
        out_a_from_b = 1'b0;
        out_b_zero   = 1'b0;
        unique case (state_q)
            MODE_LOGIC: begin
            end
            MODE_RAM_SPLIT: begin
                we_t = {wr_en, wr_en};
            end
            MODE_RAM_WIDE: begin
                we_t    = {wr_en, wr_en};
                waddr_b = addr_a;
                raddr_b = addr_a;
            end
            MODE_RAM_DEEP: begin
                we_t         = {wr_en & addr_b[0], wr_en & ~addr_b[0]};
                waddr_b      = addr_a;
                wbit_t       = {wr_data[0], wr_data[0]};
                raddr_b      = addr_a;
                out_a_from_b = addr_b[0];
                out_b_zero   = 1'b1;
            end
            MODE_RAM_DUAL: begin
                we_t    = {wr_en, wr_en};
                waddr_b = addr_a;
                wbit_t  = {wr_data[0], wr_data[0]};
            end
            MODE_SHIFT: begin
                sh_en = wr_en;
            end
        endcase
    end

endmodule

// File: rtl/lut_pair_slice.sv
module lut_pair_slice
    import lutp_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int NTAB  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [2:0]        cfg_mode,
    input  logic [DEPTH-1:0]  cfg_init_a,
    input  logic [DEPTH-1:0]  cfg_init_b,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic              wr_en,
    input  logic [1:0]        wr_data,
    input  logic              shift_in,
    output logic              lut_out_a,
    output logic              lut_out_b,
    output logic              shift_out
);

    lutp_mode_e                   mode_q;
    logic [NTAB-1:0]              we_t;
    logic [NTAB-1:0]              wbit_t;
    logic [NTAB-1:0][ADDR_W-1:0]  waddr_t;
    logic [NTAB-1:0][ADDR_W-1:0]  raddr_t;
    logic [NTAB-1:0][DEPTH-1:0]   init_t;
    logic [NTAB-1:0]              shin_t;
    logic [NTAB-1:0]              rd_t;
    logic [NTAB-1:0]              last_t;
    logic                         sh_en;
    logic                         out_a_from_b;
    logic                         out_b_zero;

    lutp_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_load     (cfg_load),
        .cfg_mode     (cfg_mode),
        .addr_a       (addr_a),
        .addr_b       (addr_b),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .mode         (mode_q),
        .we_t         (we_t),
        .waddr_a      (waddr_t[0]),
        .waddr_b      (waddr_t[1]),
        .wbit_t       (wbit_t),
        .sh_en        (sh_en),
        .raddr_a      (raddr_t[0]),
        .raddr_b      (raddr_t[1]),
        .out_a_from_b (out_a_from_b),
        .out_b_zero   (out_b_zero)
    );

    assign init_t[0] = cfg_init_a;
    assign init_t[1] = cfg_init_b;
    assign shin_t[0] = shift_in;
    assign shin_t[1] = last_t[0];

    for (genvar t = 0; t < NTAB; t++) begin : g_tab
        lutp_table #(.ADDR_W(ADDR_W)) u_tab (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (cfg_load),
            .init     (init_t[t]),
            .we       (we_t[t]),
            .waddr    (waddr_t[t]),
            .wbit     (wbit_t[t]),
            .sh_en    (sh_en),
            .sh_in    (shin_t[t]),
            .raddr    (raddr_t[t]),
            .rdata    (rd_t[t]),
            .tap_last (last_t[t])
        );
    end

    assign lut_out_a = out_a_from_b ? rd_t[1] : rd_t[0];
    assign lut_out_b = out_b_zero ? 1'b0 : rd_t[1];
    assign shift_out = last_t[1];

endmodule

// File: rtl/lutp_checker.sv
module lutp_checker
    import lutp_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_load,
    input logic [2:0]        cfg_mode,
    input logic [DEPTH-1:0]  cfg_init_a,
    input logic [ADDR_W-1:0] addr_a,
    input logic [ADDR_W-1:0] addr_b,
    input logic              wr_en,
    input logic [1:0]        wr_data,
    input logic              shift_in,
    input logic              lut_out_a,
    input logic              lut_out_b,
    input lutp_mode_e        mode
);

    // R4: a read-only function keeps its output while the address holds.
    p_logic_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOGIC && !cfg_load)
        |=> (!$stable(addr_a) || $stable(lut_out_a)));

    // R6: a write in the wide memory reads back on both outputs.
    p_wide_readback_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RAM_WIDE && wr_en && !cfg_load)
        |=> (!$stable(addr_a) ||
             (lut_out_a == $past(wr_data[0]) && lut_out_b == $past(wr_data[1]))));

    // R8: the read-only port sees a write made through the other port.
    p_dual_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RAM_DUAL && wr_en && !cfg_load)
        |=> (addr_b != $past(addr_a) || lut_out_b == $past(wr_data[0])));

    // R9: after a shift step tap 0 holds the serial input.
    p_shift_tap0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SHIFT && wr_en && !cfg_load)
        |=> (addr_a != '0 || lut_out_a == $past(shift_in)));

    // R7: the deep memory drives nothing on the second output.
    p_deep_b_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RAM_DEEP) |-> !lut_out_b);

    // R2: a load into logic mode presents the new image at once.
    p_load_image_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && cfg_mode == 3'd0)
        |=> (!$stable(addr_a) || lut_out_a == $past(cfg_init_a[addr_a])));

endmodule

bind lut_pair_slice lutp_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_load   (cfg_load),
    .cfg_mode   (cfg_mode),
    .cfg_init_a (cfg_init_a),
    .addr_a     (addr_a),
    .addr_b     (addr_b),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .shift_in   (shift_in),
    .lut_out_a  (lut_out_a),
    .lut_out_b  (lut_out_b),
    .mode       (mode_q)
);

// File: tb/lut_pair_slice_tb.sv
module lut_pair_slice_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [2:0]  cfg_mode = 3'd0;
    logic [15:0] cfg_init_a = '0;
    logic [15:0] cfg_init_b = '0;
    logic [3:0]  addr_a = '0;
    logic [3:0]  addr_b = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_data = '0;
    logic        shift_in = 1'b0;
    logic        lut_out_a, lut_out_b, shift_out;

    int checks = 0;
    int errors = 0;
    logic [15:0] ma, mb;
    int mmode;

    always #4 clk = ~clk;

    lut_pair_slice u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
        .cfg_init_a(cfg_init_a), .cfg_init_b(cfg_init_b),
        .addr_a(addr_a), .addr_b(addr_b), .wr_en(wr_en), .wr_data(wr_data),
        .shift_in(shift_in), .lut_out_a(lut_out_a), .lut_out_b(lut_out_b),
        .shift_out(shift_out)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b (mode %0d a=%0d b=%0d)",
                     req, act, exp, mmode, addr_a, addr_b);
        end
    endtask

    // Sweep 32 address pairs; addr_b[0] covers both table selects.
    task automatic check_reads(input string req);
        for (int i = 0; i < 32; i++) begin
            logic ea, eb;
            addr_a = i[3:0];
            addr_b = {i[2:0] ^ 3'b101, i[4]};
            #1;
            if (mmode == 3) ea = addr_b[0] ? mb[addr_a] : ma[addr_a];
            else            ea = ma[addr_a];
            if (mmode == 3)      eb = 1'b0;
            else if (mmode == 2) eb = mb[addr_a];
            else                 eb = mb[addr_b];
            chk(req, lut_out_a, ea);
            chk(req, lut_out_b, eb);
        end
        chk({req, " R10"}, shift_out, mb[15]);
    endtask

    // One edge with the given stimulus, then the model follows the requirements.
    task automatic cycle(input logic we, input logic [3:0] aa, input logic [3:0] ab,
                         input logic [1:0] wd, input logic si);
        @(negedge clk);
        addr_a = aa; addr_b = ab; wr_en = we; wr_data = wd; shift_in = si;
        @(posedge clk);
        if (we) begin
            case (mmode)
                1: begin ma[aa] = wd[0]; mb[ab] = wd[1]; end
                2: begin ma[aa] = wd[0]; mb[aa] = wd[1]; end
                3: if (ab[0]) mb[aa] = wd[0]; else ma[aa] = wd[0];
                4: begin ma[aa] = wd[0]; mb[aa] = wd[0]; end
                5: begin mb = {mb[14:0], ma[15]}; ma = {ma[14:0], si}; end
                default: ;
            endcase
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Load with a concurrent write request that must lose (R2).
    task automatic load(input logic [2:0] code, input logic [15:0] ia, input logic [15:0] ib);
        @(negedge clk);
        cfg_load = 1'b1; cfg_mode = code; cfg_init_a = ia; cfg_init_b = ib;
        wr_en = 1'b1; wr_data = 2'b11; shift_in = 1'b1; addr_a = 4'd3; addr_b = 4'd3;
        @(posedge clk);
        ma = ia; mb = ib;
        mmode = (code > 3'd5) ? 0 : int'(code);
        @(negedge clk);
        cfg_load = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        ma = '0; mb = '0; mmode = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        check_reads("R1 reset");

        // R2, R3, R4: function contents, then attempted writes and shifts.
        load(3'd0, 16'hA5C3, 16'h3C96);
        check_reads("R2 R3 logic");
        for (int k = 0; k < 16; k++) cycle(1'b1, k[3:0], ~k[3:0], 2'(~k), k[0]);
        check_reads("R4 logic ignore");

        // R11: unused code behaves as logic.
        load(3'd6, 16'h0F0F, 16'hF00F);
        for (int k = 0; k < 16; k++) cycle(1'b1, k[3:0], k[3:0], 2'b10 ^ 2'(k), 1'b1);
        check_reads("R11 code6");
        load(3'd7, 16'h1234, 16'h8765);
        cycle(1'b1, 4'd1, 4'd2, 2'b11, 1'b1);
        check_reads("R11 code7");

        // R5: independent tables.
        load(3'd1, 16'h0000, 16'hFFFF);
        for (int k = 0; k < 16; k++) cycle(1'b1, k[3:0], 4'(15 - k), 2'(k * 3), 1'b0);
        check_reads("R5 split");

        // R6: shared address, two data bits.
        load(3'd2, 16'h5555, 16'h0000);
        for (int k = 0; k < 16; k += 2) cycle(1'b1, k[3:0], 4'd7, 2'(k / 2), 1'b0);
        check_reads("R6 wide");

        // R7: 32 entries across both tables.
        load(3'd3, 16'hFFFF, 16'h0000);
        for (int k = 0; k < 32; k++) cycle(1'b1, k[3:0], {3'b000, k[4]}, 2'((k * 5) % 3), 1'b0);
        check_reads("R7 deep");

        // R8: two ports, mirrored contents.
        load(3'd4, 16'h0000, 16'h0000);
        for (int k = 0; k < 16; k++) cycle(1'b1, k[3:0], 4'd0, {1'b0, k[1] ^ k[3]}, 1'b0);
        check_reads("R8 dual");

        // R9, R10: 40 shift steps through the cascade, with idle edges between.
        load(3'd5, 16'h8001, 16'h00F0);
        for (int k = 0; k < 40; k++) begin
            cycle(1'b1, 4'd0, 4'd0, 2'b00, ((k * 7 + 3) % 5) < 2);
            if (k % 8 == 7) begin
                cycle(1'b0, 4'd0, 4'd0, 2'b00, 1'b1);
                check_reads("R9 R10 shift");
            end
        end
        check_reads("R9 shift end");

        // R1: reset again clears everything.
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        ma = '0; mb = '0; mmode = 0;
        check_reads("R1 re-reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule